// File: doc/BRIEF.md
# Multi-Core Burst Request Issuer

This block decides, cycle by cycle, which processor core may push its oldest pending memory request into the shared DRAM request buffers. It does not rotate between cores on every request. It stays with one core for a short burst of back-to-back requests, so that requests from that core which target different banks reach the buffers together and can be serviced in parallel.

The burst length is capped. When the cap is reached, or when the current core runs dry, the issuer moves to the core with the lightest memory traffic. Each core reports its last-level cache misses as single-cycle pulses. The block counts these pulses over a fixed interval. At the end of every interval it ranks the cores, so that the core with the fewest misses comes first. The interval counts then restart.

The grant is combinational from the current state and the request inputs. A downstream buffer accepts the granted request in the same cycle in which `buf_ready` is high.

Top module: `core_burst_issuer`

## Requirements
- R1: After reset the selected core is core 0, its burst count is zero, and the rank order follows core index, with core 0 first.
- R2: `grant` is one-hot or zero. `grant_valid` is high exactly when some core is granted. `grant_core` gives the index of the granted core, and that core has a pending request.
- R3: While the selected core has a pending request and its burst count is below `SEND_LIMIT`, that core is granted and the count increases by one.
- R4: When the burst count has reached `SEND_LIMIT`, the issuer reselects the best-ranked core that has a pending request. This may be the same core. The count restarts, so it reads 1 after that grant.
- R5: When the selected core has nothing pending but another core does, the issuer reselects the best-ranked pending core in the same way as in R4, and the count restarts at 1.
- R6: The rank order sorts cores by ascending miss count of the last closed interval. Equal counts are ordered by lower core index. Only cores with a pending request take part in reselection.
- R7: The ranks are recomputed once every `RANK_PERIOD` cycles after reset. In that cycle every miss counter restarts. A miss pulse arriving in that same cycle counts as the first miss of the new interval.
- R8: Each miss counter saturates at its maximum value, 2^`MISS_W` - 1, and does not wrap.
- R9: When `buf_ready` is low, or when no core has a pending request, there is no grant and the selected core and burst count keep their values. Miss counting and the interval timer continue regardless.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_pending | input | NCORES | Per core: the oldest queued request is valid |
| miss_pulse | input | NCORES | Per core: one last-level cache miss this cycle |
| buf_ready | input | 1 | The shared request buffers can accept a request this cycle |
| grant | output | NCORES | One-hot grant to the core whose oldest request is sent |
| grant_valid | output | 1 | A request is issued this cycle |
| grant_core | output | $clog2(NCORES) | Index of the granted core |

## Verification
The hardest situation to reach is a limit-triggered reselection in which the ranks differ from index order. This needs a full burst on one core while the other cores are still pending, and it needs a recomputation that has already run on unequal miss traffic, some of it saturated. The bench uses a small configuration with a short interval, a burst cap of four and narrow miss counters. It drives skewed miss pulse rates per core, so that the rank order changes from interval to interval and the heaviest core saturates. It holds every pending mask for several cycles in turn, with the buffer ready and not ready. Long stretches with all cores pending force repeated cap-triggered switches under changing ranks.

// File: rtl/cbi_pkg.sv
package cbi_pkg;

  typedef enum logic [1:0] {
    ISS_IDLE   = 2'd0,
    ISS_STAY   = 2'd1,
    ISS_SWITCH = 2'd2
  } iss_kind_e;

endpackage

// File: rtl/cbi_epoch_timer.sv
module cbi_epoch_timer #(
  parameter int PERIOD = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    tick  = (tmr_q == LAST);
    tmr_d = tick ? '0 : tmr_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end
endmodule

// File: rtl/cbi_miss_bank.sv
module cbi_miss_bank #(
  parameter int NCORES = 4,
  parameter int MISS_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NCORES-1:0]              miss_pulse,
  input  logic                           restart,
  output logic [NCORES-1:0][MISS_W-1:0]  counts
);
  localparam logic [MISS_W-1:0] SAT = '1;

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    logic [MISS_W-1:0] cnt_q, cnt_d;
    logic              cnt_en;

    always_comb begin
      cnt_en = restart | (miss_pulse[c] & (cnt_q != SAT));
      if (restart) cnt_d = miss_pulse[c] ? MISS_W'(1) : '0;
      else         cnt_d = cnt_q + MISS_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign counts[c] = cnt_q;
  end
endmodule

// File: rtl/cbi_rank_table.sv
module cbi_rank_table #(
  parameter int NCORES = 4,
  parameter int MISS_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           update,
  input  logic [NCORES-1:0][MISS_W-1:0]  counts,
  output logic [NCORES-1:0][IDX_W-1:0]   rank_pos
);
  logic [NCORES-1:0][IDX_W-1:0] pos_q, pos_d;

  // Position of a core = number of cores ordered ahead of it.
  for (genvar i = 0; i < NCORES; i++) begin : g_pos
    logic [NCORES-1:0] ahead;
    for (genvar j = 0; j < NCORES; j++) begin : g_cmp
      if (j < i) begin : g_lo
        assign ahead[j] = (counts[j] <= counts[i]);
      end else if (j > i) begin : g_hi
        assign ahead[j] = (counts[j] < counts[i]);
      end else begin : g_self
        assign ahead[j] = 1'b0;
      end
    end

    always_comb begin
      pos_d[i] = '0;
      for (int k = 0; k < NCORES; k++) begin
        pos_d[i] = pos_d[i] + IDX_W'(ahead[k]);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pos_q[i] <= IDX_W'(i);
      else if (update) pos_q[i] <= pos_d[i];
    end
  end

  assign rank_pos = pos_q;
endmodule

// File: rtl/cbi_issue_ctrl.sv
module cbi_issue_ctrl
  import cbi_pkg::*;
#(
  parameter int NCORES     = 4,
  parameter int SEND_LIMIT = 10,
  parameter int IDX_W      = 2,
  parameter int CNT_W      = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NCORES-1:0]            req_pending,
  input  logic                         buf_ready,
  input  logic [NCORES-1:0][IDX_W-1:0] rank_pos,
  output logic [NCORES-1:0]            grant,
  output logic                         grant_valid,
  output logic [IDX_W-1:0]             grant_core,
  output logic [IDX_W-1:0]             sel_q,
  output logic [CNT_W-1:0]             cnt_q
);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(SEND_LIMIT);

  logic [IDX_W-1:0] sel_d, best_idx, best_pos;
  logic [CNT_W-1:0] cnt_d;
  logic             best_found;
  iss_kind_e        kind;

  // Best-ranked core among those with a pending request.
  always_comb begin
    best_found = 1'b0;
    best_idx   = '0;
    best_pos   = '1;
    for (int i = 0; i < NCORES; i++) begin
      if (req_pending[i] && (!best_found || rank_pos[i] < best_pos)) begin
        best_found = 1'b1;
        best_idx   = IDX_W'(i);
        best_pos   = rank_pos[i];
      end
    end
  end

  always_comb begin
    kind  = ISS_IDLE;
    sel_d = sel_q;
    cnt_d = cnt_q;
    if (buf_ready && best_found) begin
      if (req_pending[sel_q] && cnt_q < LIMIT_C) begin
        kind  = ISS_STAY;
        cnt_d = cnt_q + CNT_W'(1);
      end else begin
        kind  = ISS_SWITCH;
        sel_d = best_idx;
        cnt_d = CNT_W'(1);
      end
    end
  end

  always_comb begin
    grant_valid = (kind != ISS_IDLE);
    grant_core  = sel_d;
    for (int i = 0; i < NCORES; i++) begin
      grant[i] = grant_valid && (sel_d == IDX_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else if (kind != ISS_IDLE) begin
      sel_q <= sel_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/core_burst_issuer.sv
module core_burst_issuer #(
  parameter int NCORES      = 4,
  parameter int MISS_W      = 16,
  parameter int RANK_PERIOD = 100000,
  parameter int SEND_LIMIT  = 10,
  localparam int IDX_W      = $clog2(NCORES),
  localparam int CNT_W      = $clog2(SEND_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCORES-1:0] req_pending,
  input  logic [NCORES-1:0] miss_pulse,
  input  logic              buf_ready,
  output logic [NCORES-1:0] grant,
  output logic              grant_valid,
  output logic [IDX_W-1:0]  grant_core
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic                          epoch_tick;
  logic [NCORES-1:0][MISS_W-1:0] miss_counts;
  logic [NCORES-1:0][IDX_W-1:0]  rank_pos;
  logic [IDX_W-1:0]              sel_q;
  logic [CNT_W-1:0]              cnt_q;

  cbi_epoch_timer #(.PERIOD(RANK_PERIOD)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (epoch_tick)
  );

  cbi_miss_bank #(.NCORES(NCORES), .MISS_W(MISS_W)) u_miss (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .miss_pulse (miss_pulse),
    .restart    (epoch_tick),
    .counts     (miss_counts)
  );

  cbi_rank_table #(.NCORES(NCORES), .MISS_W(MISS_W), .IDX_W(IDX_W)) u_rank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .update   (epoch_tick),
    .counts   (miss_counts),
    .rank_pos (rank_pos)
  );

  cbi_issue_ctrl #(
    .NCORES(NCORES), .SEND_LIMIT(SEND_LIMIT), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_issue (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_pending (req_pending),
    .buf_ready   (buf_ready),
    .rank_pos    (rank_pos),
    .grant       (grant),
    .grant_valid (grant_valid),
    .grant_core  (grant_core),
    .sel_q       (sel_q),
    .cnt_q       (cnt_q)
  );
endmodule

// File: rtl/cbi_checker.sv
module cbi_checker #(
  parameter int NCORES     = 4,
  parameter int IDX_W      = 2,
  parameter int CNT_W      = 4,
  parameter int SEND_LIMIT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCORES-1:0] req_pending,
  input logic              buf_ready,
  input logic [NCORES-1:0] grant,
  input logic              grant_valid,
  input logic [IDX_W-1:0]  grant_core,
  input logic [IDX_W-1:0]  sel_q,
  input logic [CNT_W-1:0]  cnt_q
);
  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (req_pending[grant_core] && buf_ready && grant[grant_core]));

  assert_stick_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && req_pending[sel_q] && int'(cnt_q) < SEND_LIMIT) |-> (grant_core == sel_q));

  assert_count_after_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |=> (cnt_q != '0));

  assert_count_capped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= SEND_LIMIT);

  assert_hold_when_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_ready |=> (sel_q == $past(sel_q) && cnt_q == $past(cnt_q)));

  assert_no_grant_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_ready || req_pending == '0) |-> !grant_valid);
endmodule

bind core_burst_issuer cbi_checker #(
  .NCORES(NCORES), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEND_LIMIT(SEND_LIMIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .req_pending (req_pending),
  .buf_ready   (buf_ready),
  .grant       (grant),
  .grant_valid (grant_valid),
  .grant_core  (grant_core),
  .sel_q       (sel_q),
  .cnt_q       (cnt_q)
);

// File: tb/core_burst_issuer_tb.sv
module core_burst_issuer_tb;
  localparam int N  = 4;
  localparam int MW = 4;
  localparam int P  = 32;
  localparam int L  = 4;
  localparam int IW = 2;
  localparam int SAT = (1 << MW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req_pending, miss_pulse;
  logic          buf_ready;
  logic [N-1:0]  grant;
  logic          grant_valid;
  logic [IW-1:0] grant_core;

  int total = 0, bad = 0;
  bit done = 0;

  int m_miss[N];
  int m_pos[N];
  int m_tmr, m_sel, m_cnt;

  always #4 clk = ~clk;

  core_burst_issuer #(.NCORES(N), .MISS_W(MW), .RANK_PERIOD(P), .SEND_LIMIT(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_pending(req_pending), .miss_pulse(miss_pulse),
    .buf_ready(buf_ready), .grant(grant), .grant_valid(grant_valid), .grant_core(grant_core)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_miss[i] = 0; m_pos[i] = i; end
    m_tmr = 0; m_sel = 0; m_cnt = 0;
  endtask

  // One cycle: drive at negedge, check combinational grant, then advance model past the posedge.
  task automatic step(input logic [N-1:0] pend, input logic [N-1:0] pulse,
                      input logic rdy, input string tagov);
    int kind, ec, best, bp;
    string tag;
    logic [N-1:0] eg;
    @(negedge clk);
    req_pending = pend; miss_pulse = pulse; buf_ready = rdy;
    #1;
    best = -1; bp = N + 1;
    for (int i = 0; i < N; i++)
      if (pend[i] && m_pos[i] < bp) begin bp = m_pos[i]; best = i; end
    kind = 0; ec = m_sel; tag = "R9";
    if (rdy && best >= 0) begin
      if (pend[m_sel] && m_cnt < L) begin kind = 1; tag = "R3"; end
      else begin
        kind = 2; ec = best;
        tag = pend[m_sel] ? "R4 R6 R7 R8" : "R5 R6 R7 R8";
      end
    end
    if (tagov != "") tag = tagov;
    eg = '0;
    if (kind != 0) eg[ec] = 1'b1;
    check(grant_valid == (kind != 0), {tag, " R2 valid"}, grant_valid, kind != 0);
    check(grant == eg, {tag, " grant"}, grant, eg);
    if (kind != 0) check(grant_core == IW'(ec), {tag, " core"}, grant_core, ec);
    // model update
    if (kind == 1) m_cnt++;
    else if (kind == 2) begin m_sel = ec; m_cnt = 1; end
    if (m_tmr == P - 1) begin
      for (int i = 0; i < N; i++) begin
        m_pos[i] = 0;
        for (int j = 0; j < N; j++)
          if (m_miss[j] < m_miss[i] || (m_miss[j] == m_miss[i] && j < i)) m_pos[i]++;
      end
      for (int i = 0; i < N; i++) m_miss[i] = pulse[i] ? 1 : 0;
      m_tmr = 0;
    end else begin
      for (int i = 0; i < N; i++) if (pulse[i] && m_miss[i] < SAT) m_miss[i]++;
      m_tmr++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pl;
    rst_n = 1'b0; req_pending = '0; miss_pulse = '0; buf_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);   // internal reset release takes two edges
    model_reset();

    // R1: core 0 not pending -> index order picks core 1
    step(4'b1010, '0, 1'b1, "R1");
    step(4'b0000, '0, 1'b1, "R9 idle");
    // reset once more, then core 0 selected with all pending
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);
    model_reset();
    step(4'b1111, '0, 1'b1, "R1");

    // Sweep all pending masks, buffer blocked and ready, each held a few cycles
    for (int m = 0; m < (1 << N); m++)
      for (int r = 0; r < 2; r++)
        for (int k = 0; k < 6; k++)
          step(N'(m), '0, r[0], "");

    // Skewed miss traffic, random pending, mostly ready
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < N; i++) pl[i] = (($urandom % 8) < (((c / 400) + i) % N) * 2);
      step(N'($urandom), pl, ($urandom % 8) != 0, "");
    end

    // All pending: repeated cap-triggered switches under changing ranks
    for (int c = 0; c < 2000; c++) begin
      for (int i = 0; i < N; i++) pl[i] = (($urandom % 8) < (((c / 150) + 3 * i) % 5) * 2);
      step('1, pl, ($urandom % 16) != 0, "");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule